// File: doc/BRIEF.md
# Framed Word Receiver Validator

This block takes a serial bit stream made of fixed-length framed words and checks each word as it completes. A word starts with a frame bit, carries a data byte and a 6-bit check code, and is closed by a frame bit that also opens the following word. While the frame bit and the data byte arrive, the block builds the check code it expects. When the closing frame bit arrives, it compares that code with the one received. It also requires the closing frame bit to be the inverse of the opening one.

At each word boundary the block latches the data byte and a valid flag, then pulses a strobe. The host uses the rising edge of that strobe as its interrupt and reads the latched byte and flag at leisure. Word alignment is not searched for here. The host owns frame acquisition and tells the block where a word starts through an align input.

Top module: `frw_receiver`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `word_data` is 0, `word_valid` is 0 and `word_stb` is 0. Reset also marks the next accepted bit as an opening frame bit.
- R2: A bit is accepted on a rising `clk` edge where `bit_en` is 1 and `align` is 0. A word is 15 accepted bits in this order: opening frame bit, 8 data bits with the MSB first, then 6 check bits with the MSB first. The next accepted bit closes the word and is also the opening frame bit of the next word.
- R3: The expected check code comes from a 6-bit shift register seeded with 0. It takes in the opening frame bit and then the data bits, in arrival order. For each bit, the feedback is the register's MSB XOR the bit. The register shifts left, and when the feedback is 1 it is XORed with 0x03 (polynomial x^6+x+1).
- R4: `word_valid` is latched as 1 only if two conditions both hold: the received check bits equal the expected code, and the closing frame bit differs from the opening frame bit.
- R5: When a word's closing bit is accepted, `word_stb` is 1 for exactly one clock cycle, starting with the next rising edge. `word_data` and `word_valid` take their new values on that same edge.
- R6: `word_data` and `word_valid` change only on the edge that raises `word_stb`. Bits accepted in the middle of a word leave them unchanged.
- R7: A cycle with `align` high discards any partial word and raises no strobe. The next accepted bit is then an opening frame bit, and no strobe comes until 15 more bits plus a closing bit have been accepted.
- R8: While `bit_en` is 0, `bit_in` has no effect on any output or on word position.
- R9: In an unbroken stream, a strobe comes once every 15 accepted bits, with none in between.
- R10: A word that fails either check still has its data byte latched, with `word_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks the cycle in which `bit_in` carries a line bit |
| bit_in | input | 1 | Serial line bit |
| align | input | 1 | Restarts word position; next accepted bit opens a word |
| word_data | output | 8 | Data byte of the last completed word |
| word_valid | output | 1 | Check result of the last completed word |
| word_stb | output | 1 | One-cycle pulse per completed word (host interrupt edge) |

## Verification
The assertions check several properties on every cycle:
- the bit-position counter stays in range and wraps after 15 accepted bits;
- the counter holds when no bit is accepted, and align clears it;
- the strobe lasts a single cycle and follows an accepted bit;
- the outputs hold between strobes;
- the latched byte matches the captured one;
- a valid flag never accompanies a closing frame bit equal to the opening one.

Only the bench's scenarios can show the other properties. These are that the check code matches the polynomial for many data patterns, that single-bit and multi-bit check errors and bad frame bits clear the flag, and that align and reset in the middle of a word restart word counting at the right bit.

// File: rtl/frw_pkg.sv
package frw_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   // Accepted bits per word, excluding the shared closing frame bit
   function automatic int word_len(input int data_w, input int chk_w);
      return 1 + data_w + chk_w;
   endfunction

endpackage

// File: rtl/frw_bit_counter.sv
module frw_bit_counter #(
   parameter int WORD_LEN = 15,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic align,
   output logic take,
   output logic is_lead,
   output logic is_data,
   output logic is_chk,
   output logic eval
);
   localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(WORD_LEN - 1);
   localparam logic [CNT_W-1:0] FIRST_DAT = CNT_W'(1);
   localparam logic [CNT_W-1:0] LAST_DAT  = CNT_W'(DATA_W);

   if ((1 << CNT_W) < WORD_LEN) begin : g_chk_cnt_w
      $error("frw_bit_counter: CNT_W too small for WORD_LEN");
   end

   logic [CNT_W-1:0] pos_q;
   logic             open_q;

   assign take    = bit_en && !align;
   assign is_lead = (pos_q == '0);
   assign is_data = (pos_q >= FIRST_DAT) && (pos_q <= LAST_DAT);
   assign is_chk  = (pos_q > LAST_DAT);
   assign eval    = take && is_lead && open_q;

   always_ff @(posedge clk) begin
      if (!rst_n || align) begin
         pos_q  <= '0;
         open_q <= 1'b0;
      end else if (bit_en) begin
         pos_q  <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
         if (pos_q == '0) open_q <= 1'b1;
      end
   end

   a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST_POS);
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pos_q == LAST_POS) |=> (pos_q == '0));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !align) |=> ($stable(pos_q) && $stable(open_q)));
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      align |=> (pos_q == '0 && !open_q));

endmodule

// File: rtl/frw_chk_gen.sv
module frw_chk_gen #(
   parameter int                CHK_W = 6,
   parameter logic [CHK_W-1:0]  POLY  = 6'h03,
   parameter logic [CHK_W-1:0]  SEED  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             bit_in,
   input  logic             is_lead,
   input  logic             is_data,
   output logic [CHK_W-1:0] chk_exp
);
   if (CHK_W < 2) begin : g_chk_w
      $error("frw_chk_gen: CHK_W must be at least 2");
   end

   logic [CHK_W-1:0] reg_q;
   logic [CHK_W-1:0] base;
   logic [CHK_W-1:0] nxt;
   logic             fb;

   // Opening frame bit restarts the code from the seed
   assign base = is_lead ? SEED : reg_q;
   assign fb   = base[CHK_W-1] ^ bit_in;

   for (genvar i = 0; i < CHK_W; i++) begin : g_lfsr
      if (i == 0) begin : g_lsb
         assign nxt[i] = fb & POLY[i];
      end else begin : g_up
         assign nxt[i] = base[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= SEED;
      end else if (take && (is_lead || is_data)) begin
         reg_q <= nxt;
      end
   end

   assign chk_exp = reg_q;

   a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && (is_lead || is_data)) |=> $stable(reg_q));

endmodule

// File: rtl/frw_capture.sv
module frw_capture #(
   parameter int                 DATA_W = 8,
   parameter int                 CHK_W  = 6,
   parameter frw_pkg::bit_order_e ORDER = frw_pkg::ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              bit_in,
   input  logic              is_lead,
   input  logic              is_data,
   input  logic              is_chk,
   output logic              lead_q,
   output logic [DATA_W-1:0] data_q,
   output logic [CHK_W-1:0]  chk_rx_q
);
   if (DATA_W < 2) begin : g_data_w
      $error("frw_capture: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] data_nxt;

   if (ORDER == frw_pkg::ORDER_MSB_FIRST) begin : g_msb
      assign data_nxt = {data_q[DATA_W-2:0], bit_in};
   end else begin : g_lsb
      assign data_nxt = {bit_in, data_q[DATA_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lead_q   <= 1'b0;
         data_q   <= '0;
         chk_rx_q <= '0;
      end else if (take) begin
         if (is_lead) lead_q   <= bit_in;
         if (is_data) data_q   <= data_nxt;
         if (is_chk)  chk_rx_q <= {chk_rx_q[CHK_W-2:0], bit_in};
      end
   end

   a_r2_lead_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && is_lead) |=> $stable(lead_q));

endmodule

// File: rtl/frw_receiver.sv
module frw_receiver #(
   parameter int                  DATA_W = 8,
   parameter int                  CHK_W  = 6,
   parameter logic [CHK_W-1:0]    POLY   = 6'h03,
   parameter logic [CHK_W-1:0]    SEED   = '0,
   parameter frw_pkg::bit_order_e ORDER  = frw_pkg::ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              align,
   output logic [DATA_W-1:0] word_data,
   output logic              word_valid,
   output logic              word_stb
);
   localparam int WORD_LEN = frw_pkg::word_len(DATA_W, CHK_W);
   localparam int CNT_W    = $clog2(WORD_LEN);

   logic              take, is_lead, is_data, is_chk, eval;
   logic              lead_q;
   logic [DATA_W-1:0] data_q;
   logic [CHK_W-1:0]  chk_rx_q, chk_exp;
   logic              word_ok;

   frw_bit_counter #(.WORD_LEN(WORD_LEN), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .align(align),
      .take(take), .is_lead(is_lead), .is_data(is_data), .is_chk(is_chk),
      .eval(eval)
   );

   frw_chk_gen #(.CHK_W(CHK_W), .POLY(POLY), .SEED(SEED)) u_gen (
      .clk(clk), .rst_n(rst_n), .take(take), .bit_in(bit_in),
      .is_lead(is_lead), .is_data(is_data), .chk_exp(chk_exp)
   );

   frw_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ORDER(ORDER)) u_cap (
      .clk(clk), .rst_n(rst_n), .take(take), .bit_in(bit_in),
      .is_lead(is_lead), .is_data(is_data), .is_chk(is_chk),
      .lead_q(lead_q), .data_q(data_q), .chk_rx_q(chk_rx_q)
   );

   // bit_in at eval is the closing frame bit of the finished word
   assign word_ok = (chk_rx_q == chk_exp) && (bit_in != lead_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_data  <= '0;
         word_valid <= 1'b0;
         word_stb   <= 1'b0;
      end else begin
         word_stb <= eval;
         if (eval) begin
            word_data  <= data_q;
            word_valid <= word_ok;
         end
      end
   end

   a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);
   a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> ($past(bit_en) && !$past(align)));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !word_stb |-> ($stable(word_data) && $stable(word_valid)));
   a_r4_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && word_valid) |-> ($past(bit_in) != $past(lead_q)));
   a_r10_data: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> (word_data == $past(data_q)));

endmodule

// File: tb/tb_frw_receiver.sv
`timescale 1ns/1ps
module tb_frw_receiver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic       align = 1'b0;
   logic [7:0] word_data;
   logic       word_valid;
   logic       word_stb;

   int n_chk = 0;
   int n_fail = 0;
   int strobes = 0;
   logic last_stb = 1'b0;

   always #10 clk = ~clk;

   frw_receiver dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .align(align), .word_data(word_data), .word_valid(word_valid),
      .word_stb(word_stb)
   );

   // {bad closing frame bit, check-bit error mask[5:0], data[7:0]}
   localparam int NVEC = 10;
   localparam logic [14:0] VEC [0:NVEC-1] = '{
      15'h00A5, 15'h0000, 15'h00FF, 15'h013C, 15'h0081,
      15'h407E, 15'h0055, 15'h20C3, 15'h0012, 15'h7F99
   };

   function automatic logic [5:0] ref_chk(input logic f, input logic [7:0] d);
      logic [8:0] s;
      logic [5:0] c;
      logic       fb;
      s = {f, d};
      c = 6'h00;
      for (int i = 8; i >= 0; i--) begin
         fb = c[5] ^ s[i];
         c  = {c[4:0], 1'b0};
         if (fb) c = c ^ 6'h03;
      end
      return c;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b;
      @(negedge clk);
      bit_en   = 1'b0;
      bit_in   = 1'($urandom);
      last_stb = word_stb;
      if (word_stb) strobes++;
   endtask

   task automatic send_body(input logic [7:0] d, input logic [5:0] c);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      for (int i = 5; i >= 0; i--) send_bit(c[i]);
   endtask

   task automatic pulse_align();
      @(negedge clk);
      align  = 1'b1;
      bit_en = 1'b1;
      bit_in = 1'($urandom);
      @(negedge clk);
      align  = 1'b0;
      bit_en = 1'b0;
      if (word_stb) strobes++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      logic       lead, trail, bad;
      logic [7:0] d;
      logic [5:0] err, held_d;
      logic       held_v;
      int         s0;

      repeat (3) @(negedge clk);
      check(word_data == 8'h00, "R1 data in reset", word_data, 0);
      check(word_valid == 1'b0, "R1 valid in reset", word_valid, 0);
      check(word_stb == 1'b0, "R1 strobe in reset", word_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(word_data == 8'h00 && !word_valid && !word_stb, "R1 after release",
            {word_data, word_valid, word_stb}, 0);

      // Table walk: continuous stream, each closing bit opens the next word
      lead = 1'b0;
      send_bit(lead);
      for (int k = 0; k < NVEC; k++) begin
         d   = VEC[k][7:0];
         err = VEC[k][13:8];
         bad = VEC[k][14];
         s0  = strobes;
         send_body(d, ref_chk(lead, d) ^ err);
         check(strobes == s0, "R9 no strobe inside word", strobes - s0, 0);
         trail = bad ? lead : ~lead;
         send_bit(trail);
         check(last_stb == 1'b1, "R5 strobe after closing bit", last_stb, 1);
         check(word_data == d, "R2 R10 latched data", word_data, d);
         check(word_valid == (err == 6'h00 && !bad), "R3 R4 valid flag",
               word_valid, (err == 6'h00 && !bad));
         lead = trail;
      end

      // R6 R8: idle with noise on bit_in
      held_d = 6'h00;
      held_v = word_valid;
      d      = word_data;
      s0     = strobes;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         bit_in = ~bit_in;
         if (word_stb) strobes++;
      end
      check(word_data == d && word_valid == held_v && strobes == s0,
            "R8 idle bit_in ignored", {word_data, word_valid}, {d, held_v});
      // Continuing the stream: the idle noise must not have shifted position
      send_body(8'h3A, ref_chk(lead, 8'h3A));
      check(word_data == d && word_valid == held_v, "R6 stable mid-word",
            {word_data, word_valid}, {d, held_v});
      send_bit(~lead);
      check(last_stb && word_data == 8'h3A && word_valid, "R8 position kept",
            {last_stb, word_data, word_valid}, {1'b1, 8'h3A, 1'b1});
      lead = ~lead;
      if (held_d != 6'h00) $display("unused");

      // R7: align in the middle of a word
      for (int i = 0; i < 6; i++) send_bit(1'($urandom));
      s0 = strobes;
      pulse_align();
      @(negedge clk);
      check(strobes == s0 && !word_stb, "R7 no strobe on align", strobes - s0, 0);
      send_bit(1'b1);
      send_body(8'h6B, ref_chk(1'b1, 8'h6B));
      check(strobes == s0, "R7 no strobe before closing", strobes - s0, 0);
      send_bit(1'b0);
      check(last_stb && word_data == 8'h6B && word_valid, "R7 word after align",
            {last_stb, word_data, word_valid}, {1'b1, 8'h6B, 1'b1});

      // R4 R10: correct check bits but closing frame bit equals opening
      send_body(8'hC7, ref_chk(1'b0, 8'hC7));
      send_bit(1'b0);
      check(last_stb && word_data == 8'hC7 && !word_valid, "R4 bad closing frame",
            {last_stb, word_data, word_valid}, {1'b1, 8'hC7, 1'b0});

      // R1 R7: reset in mid-word, then a full word from the next bit
      for (int i = 0; i < 3; i++) send_bit(1'($urandom));
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(word_data == 8'h00 && !word_valid && !word_stb, "R1 mid-run reset",
            {word_data, word_valid, word_stb}, 0);
      rst_n = 1'b1;
      s0 = strobes;
      send_bit(1'b0);
      send_body(8'hE4, ref_chk(1'b0, 8'hE4));
      check(strobes == s0, "R7 no strobe after reset partial", strobes - s0, 0);
      send_bit(1'b1);
      check(last_stb && word_data == 8'hE4 && word_valid, "R1 first word after reset",
            {last_stb, word_data, word_valid}, {1'b1, 8'hE4, 1'b1});
      @(negedge clk);
      check(!word_stb && word_data == 8'hE4, "R5 single-cycle strobe",
            word_stb, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule